// File: doc/BRIEF.md
# Delay-Sweep Edge Distribution Sampler

This block is the digital controller of a clock-generator self-test that measures where the output clock edge falls relative to the reference clock. An external adjustable delay line, driven by this block's delay code, shifts the reference edge. A latch then samples the output clock on that shifted edge. The latch result arrives here as a one-bit sample input.

For every delay code the controller waits a short settling time, then counts how many samples were high over a fixed window of reference cycles. A plain binary counter does the counting. The controller stores the count in a result memory at the index of that code, and then moves to the next code. When the full code range has been swept, the stored counts trace the cumulative distribution of the edge position. A registered read port lets a consumer fetch the count for any code.

Top module: `dsweep_cdf_sampler`

## Requirements
- R1: After reset, delay_code_o is 0, busy_o and done_o are 0, and every result entry reads as 0.
- R2: A start_i pulse seen while the block is idle or done clears all 2^CODE_W result entries to 0 and begins a sweep at delay code 0, with busy_o high and done_o low from the next cycle.
- R3: After each delay code is applied, sample_i is ignored for SETTLE cycles (default 4).
- R4: After the settling time, the block counts the cycles within WINDOW consecutive cycles (default 1000) in which sample_i is 1.
- R5: In the cycle after the window, the count is written to the result entry indexed by the current code. If the code is below 2^CODE_W-1 it then increments by exactly one, and a new settling time starts.
- R6: After the entry for code 2^CODE_W-1 is written, busy_o falls and done_o rises. done_o stays high until the next accepted start_i.
- R7: A start_i pulse while busy_o is 1 has no effect on the delay code, the counts or the sweep timing.
- R8: rd_data_o presents the entry addressed by rd_addr_i one clock cycle after rd_addr_i is applied.
- R9: delay_code_o holds its value through the settling, counting and store cycles of its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep start pulse; clears the results |
| sample_i | input | 1 | Latched clock-output sample |
| rd_addr_i | input | CODE_W | Read address (delay code) |
| delay_code_o | output | CODE_W | Code driving the delay line |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished |
| rd_data_o | output | CNT_W | Stored ones-count for rd_addr_i |

## Verification
Once start_i is accepted, a step of code k uses the edges from offset 1+k·(SETTLE+WINDOW+1) onward. The first SETTLE edges discard samples, the next WINDOW edges count them, and the final edge stores the count. The bench drives stimulus edge by edge in exactly that sequence, so each expected count is built from the samples it placed on counting edges. Read data is due one edge after the address changes, so the bench applies addresses at one falling edge and compares them at the next. done_o is checked at the falling edge after the last store edge.

// File: rtl/dsweep_pkg.sv
package dsweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_ACCUM, ST_STORE, ST_DONE
  } sweep_state_e;
endpackage

// File: rtl/dsweep_ctrl.sv
module dsweep_ctrl
  import dsweep_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int WINDOW = 1000,
  parameter int SETTLE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [CODE_W-1:0] code_o,
  output logic              acc_clr_o,
  output logic              acc_en_o,
  output logic              wr_en_o,
  output logic              clr_all_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PH_MAX = (WINDOW > SETTLE) ? WINDOW : SETTLE;
  localparam int PH_W   = $clog2(PH_MAX) + 1;
  localparam logic [CODE_W-1:0] CODE_LAST = {CODE_W{1'b1}};
  localparam logic [PH_W-1:0]   SET_END   = PH_W'(SETTLE - 1);
  localparam logic [PH_W-1:0]   WIN_END   = PH_W'(WINDOW - 1);

  sweep_state_e state_q;
  logic [PH_W-1:0]   ph_q;
  logic [CODE_W-1:0] code_q;
  logic idle_like;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_SETTLE;
          ph_q    <= '0;
          code_q  <= '0;
        end
        ST_SETTLE: begin
          if (ph_q == SET_END) begin
            state_q <= ST_ACCUM;
            ph_q    <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        ST_ACCUM: begin
          if (ph_q == WIN_END) begin
            state_q <= ST_STORE;
            ph_q    <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        ST_STORE: begin
          if (code_q == CODE_LAST) state_q <= ST_DONE;
          else begin
            code_q  <= code_q + 1'b1;
            state_q <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o    = code_q;
  assign acc_clr_o = (state_q == ST_SETTLE);
  assign acc_en_o  = (state_q == ST_ACCUM);
  assign wr_en_o   = (state_q == ST_STORE);
  assign clr_all_o = idle_like && start_i;
  assign busy_o    = !idle_like;
  assign done_o    = (state_q == ST_DONE);

  // R5: code advances by exactly one after a non-final store
  p_code_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && code_o != CODE_LAST) |=> (code_o == $past(code_o) + 1'b1));
  // R9: code is stable while a step is in progress
  p_code_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_en_o) |=> (code_o == $past(code_o)));
  // R6: done only follows the final store
  p_done_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(wr_en_o) && $past(code_o) == CODE_LAST));
  // R7: start while busy does not restart the sweep
  p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !wr_en_o) |=> busy_o);
endmodule

// File: rtl/dsweep_accum.sv
module dsweep_accum #(
  parameter int WINDOW = 1000,
  parameter int CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             sample_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && sample_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  // R4: a window never yields more ones than it has cycles
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(WINDOW));
  // R3: samples outside the counting window leave the count unchanged
  p_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/dsweep_mem.sv
module dsweep_mem #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] waddr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CODE_W-1:0] raddr_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << CODE_W;

  logic [CNT_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (clr_i)                          mem_q[g] <= '0;
      else if (wr_i && waddr_i == CODE_W'(g))  mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;

  // R2: a clear and a write never coincide
  p_clr_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && wr_i));
endmodule

// File: rtl/dsweep_cdf_sampler.sv
module dsweep_cdf_sampler #(
  parameter int CODE_W = 6,
  parameter int WINDOW = 1000,
  parameter int SETTLE = 4,
  parameter int CNT_W  = $clog2(WINDOW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] rd_addr_i,
  output logic [CODE_W-1:0] delay_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic acc_clr, acc_en, wr_en, clr_all;
  logic [CNT_W-1:0] count;

  dsweep_ctrl #(.CODE_W(CODE_W), .WINDOW(WINDOW), .SETTLE(SETTLE)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .code_o(delay_code_o), .acc_clr_o(acc_clr), .acc_en_o(acc_en),
    .wr_en_o(wr_en), .clr_all_o(clr_all), .busy_o, .done_o
  );

  dsweep_accum #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_accum (
    .clk_i, .rst_ni, .clr_i(acc_clr), .en_i(acc_en), .sample_i,
    .count_o(count)
  );

  dsweep_mem #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_mem (
    .clk_i, .rst_ni, .clr_i(clr_all), .wr_i(wr_en),
    .waddr_i(delay_code_o), .wdata_i(count),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  // R6: busy and done are exclusive
  p_busy_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: tb/tb_dsweep_cdf_sampler.sv
module tb_dsweep_cdf_sampler;
  localparam int CODE_W = 6;
  localparam int WINDOW = 50;
  localparam int SETTLE = 4;
  localparam int CNT_W  = $clog2(WINDOW + 1);
  localparam int DEPTH  = 1 << CODE_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic sample_i = 1'b0;
  logic [CODE_W-1:0] rd_addr_i = '0;
  logic [CODE_W-1:0] delay_code_o;
  logic busy_o, done_o;
  logic [CNT_W-1:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int exp_cnt [DEPTH];

  always #2.5 clk = ~clk;

  dsweep_cdf_sampler #(.CODE_W(CODE_W), .WINDOW(WINDOW), .SETTLE(SETTLE)) dut (
    .clk_i(clk), .rst_ni, .start_i, .sample_i, .rd_addr_i,
    .delay_code_o, .busy_o, .done_o, .rd_data_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ones probability rises with code: code 0 never, last code always
  function automatic bit gen_sample(input int code);
    return $urandom_range(0, DEPTH - 2) < code;
  endfunction

  // start at a falling edge; the following edge accepts it
  task automatic do_start();
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_sweep(input int inject_step, input bit chk_clear);
    for (int k = 0; k < DEPTH; k++) begin
      int ones = 0;
      chk(delay_code_o == CODE_W'(k), "R9 code at step start", delay_code_o, k);
      chk(busy_o && !done_o, "R2 busy during sweep", {busy_o, done_o}, 2);
      for (int i = 0; i < SETTLE; i++) begin
        if (chk_clear && k == 0 && i == 1)
          chk(rd_data_o == '0, "R2 entry cleared by start", rd_data_o, 0);
        sample_i = 1'b1;   // R3: must be discarded
        @(posedge clk); @(negedge clk);
      end
      chk(delay_code_o == CODE_W'(k), "R9 code after settle", delay_code_o, k);
      for (int i = 0; i < WINDOW; i++) begin
        bit s = gen_sample(k);
        sample_i = s;
        ones += int'(s);
        start_i = (k == inject_step && i == WINDOW / 2);   // R7
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
      end
      chk(delay_code_o == CODE_W'(k), "R9 code at store", delay_code_o, k);
      sample_i = 1'b1;
      @(posedge clk); @(negedge clk);
      exp_cnt[k] = ones;
    end
    sample_i = 1'b0;
    chk(done_o && !busy_o, "R6 done after final store", {busy_o, done_o}, 1);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = CODE_W'(a);
      @(posedge clk); @(negedge clk);
      chk(rd_data_o == CNT_W'(exp_cnt[a]), tag, rd_data_o, exp_cnt[a]);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(delay_code_o == '0, "R1 reset code", delay_code_o, 0);
    chk(!busy_o && !done_o, "R1 reset flags", {busy_o, done_o}, 0);
    for (int a = 0; a < DEPTH; a++) exp_cnt[a] = 0;
    read_all("R1 R8 reset entries");

    rd_addr_i = '0;
    do_start();
    run_sweep(-1, 1'b0);
    chk(exp_cnt[0] == 0 && exp_cnt[DEPTH-1] == WINDOW, "R4 corner steps",
        exp_cnt[DEPTH-1], WINDOW);
    read_all("R4 R5 R8 sweep1 counts");

    repeat (5) @(negedge clk);
    chk(done_o, "R6 done held", done_o, 1);

    rd_addr_i = CODE_W'(DEPTH - 1);
    @(posedge clk); @(negedge clk);
    chk(rd_data_o == CNT_W'(WINDOW), "R8 last entry before restart", rd_data_o, WINDOW);
    do_start();
    run_sweep(DEPTH / 3, 1'b1);
    read_all("R5 R7 sweep2 counts");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule